// File: doc/BRIEF.md
# BCD Calendar Timekeeping Core

This core keeps wall-clock time and date as eight packed-BCD fields: seconds, minutes, hours, day of month, month, two-digit year, weekday and week number. A free-running base tick enters the block. An internal prescaler divides it down to the one-second step, and the step ripples through the field chain with carries. The day count for each month follows the month and the year, so February gets a leap day. The week number moves only when the weekday wraps, and a rule near the end of December decides whether the new week is 00 or 01.

A single-cycle load strobe replaces all eight fields at once. Two mode bits select the test behaviour. One bit skips the prescaler so that every base tick is a step. The other bit makes every field step independently on each step, with no carries between fields. A field that holds an illegal value goes back to its lowest legal value the next time it is stepped.

Top module: `bcd_calendar`

## Requirements
- R1: After reset, time_o reads week 01, weekday 01, year 00, month 01, day 01, hour 00, minute 00, second 00, that is 64'h0101_0001_0100_0000. The bytes of time_o are ordered from byte 0 to byte 7 as: second, minute, hour, day, month, year, weekday, week. load_val_i uses the same byte order.
- R2: When load_i is high at a clock edge, all eight fields take load_val_i at that edge, even if a tick arrives in the same cycle. The load also restarts the prescaler count.
- R3: With mode_i[0]=0, one step happens on every TICK_DIV-th tick counted since the last load (default 32). With mode_i[0]=1, every tick is a step.
- R4: In normal mode (mode_i[1]=0), each step advances the seconds. When a field at its top value is stepped, it wraps and carries into the next field: seconds 59 and minutes 59 wrap to 00, hours 23 wraps to 00, and the carry out of hours steps both the day and the weekday.
- R5: The last day is 31 for months 01, 03, 05, 07, 08, 10 and 12, and 30 for months 04, 06, 09 and 11. For February it is 29 when the year value is divisible by 4 (00 included) and 28 otherwise. Stepping the last day gives day 01 and a carry into the month.
- R6: Month 12 wraps to 01 and carries into the year. Year 99 wraps to 00.
- R7: The weekday counts 01 to 07, and 07 wraps to 01.
- R8: The week number changes only on a weekday wrap from 07 to 01. On that wrap, week n<52 becomes n+1. Week 52 becomes 00 if the date before the step is December 25, 26 or 27, and 01 otherwise.
- R9: When a field is stepped while it holds an illegal value, it takes its lowest legal value and sends no carry. Illegal values are a nibble above 9, a value above the field's top, or a value below its bottom. The lowest legal value is 01 for day, month and weekday, and 00 for the other fields.
- R10: With mode_i[1]=1, every field advances on each step, with its own wrap and no carries between fields. Mode 2'b10 steps at the prescaled rate and mode 2'b11 steps on every tick.
- R11: Without a step and without a load, time_o holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Base tick strobe, one clock wide per tick |
| mode_i | input | 2 | Bit 0: skip prescaler; bit 1: independent field stepping |
| load_i | input | 1 | Load strobe for all fields |
| load_val_i | input | 64 | New field values, packed BCD, second in byte 0 up to week in byte 7 |
| time_o | output | 64 | Current field values, same packing as load_val_i |

## Verification
Each stimulus vector loads a starting date and then applies a number of ticks. The starting dates cover plain second increments, carries that reach each level of the chain, and the end of each month length: 30-day months, 31-day months, February in leap and common years, and year 00. A group of dates near the year end separates the week-52 outcome for December 24 and 25 through 28 and 31. Illegal field values are placed one per vector, so a clear that wrongly leaks a carry shows up in the next field. The same dates run again in independent-stepping mode, where every byte must move by one without carries. Tick counts of 31, 32 and 64 check the prescaler length, and directed cases check that a load restarts the prescaler and wins over a coincident tick.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int NFIELD = 8;
  localparam int F_SEC = 0, F_MIN = 1, F_HOUR = 2, F_DAY = 3;
  localparam int F_MON = 4, F_YEAR = 5, F_WDAY = 6, F_WEEK = 7;

  localparam logic [7:0] FIELD_LO  [NFIELD] = '{8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 8'h01, 8'h00};
  localparam logic [7:0] FIELD_RST [NFIELD] = '{8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 8'h01, 8'h01};

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction

  function automatic logic bcd_ok(input logic [7:0] v);
    return (v[7:4] <= 4'd9) && (v[3:0] <= 4'd9);
  endfunction

  // tens*10 mod 4 equals (tens odd ? 2 : 0)
  function automatic logic is_leap(input logic [7:0] yr);
    logic [3:0] s;
    s = {2'b00, yr[4], 1'b0} + yr[3:0];
    return s[1:0] == 2'b00;
  endfunction

  function automatic logic [7:0] month_len(input logic [7:0] mon, input logic [7:0] yr);
    case (mon)
      8'h02:                      return is_leap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/cal_step_gen.sv
module cal_step_gen #(
  parameter int TICK_DIV = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic fast_i,
  input  logic clear_i,
  output logic step_o
);
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt_q;
  logic          at_last;

  assign at_last = (cnt_q == LAST);
  assign step_o  = tick_i && !clear_i && (fast_i || at_last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (tick_i)  cnt_q <= at_last ? '0 : cnt_q + CW'(1);
  end
endmodule

// File: rtl/cal_field.sv
module cal_field
  import cal_pkg::*;
#(
  parameter logic [7:0] RST_VAL = 8'h00,
  parameter logic [7:0] LO_VAL  = 8'h00
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic [7:0] load_val_i,
  input  logic       inc_i,
  input  logic [7:0] hi_i,
  input  logic [7:0] wrap_val_i,
  output logic [7:0] val_o,
  output logic       at_top_o
);
  logic [7:0] val_q;
  logic       bad;

  assign bad      = !bcd_ok(val_q) || (val_q > hi_i) || (val_q < LO_VAL);
  assign at_top_o = !bad && (val_q == hi_i);
  assign val_o    = val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       val_q <= RST_VAL;
    else if (load_i)   val_q <= load_val_i;
    else if (inc_i) begin
      if (bad)           val_q <= LO_VAL;
      else if (at_top_o) val_q <= wrap_val_i;
      else               val_q <= bcd_inc(val_q);
    end
  end
endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
  import cal_pkg::*;
#(
  parameter int TICK_DIV = 32
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tick_i,
  input  logic [1:0]  mode_i,
  input  logic        load_i,
  input  logic [63:0] load_val_i,
  output logic [63:0] time_o
);
  logic              step;
  logic [7:0]        cur  [NFIELD];
  logic [7:0]        hi   [NFIELD];
  logic [7:0]        wrap [NFIELD];
  logic [NFIELD-1:0] inc;
  logic [NFIELD-1:0] top;
  logic              week_top_unused;
  logic              yearend;

  cal_step_gen #(.TICK_DIV(TICK_DIV)) i_step (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .fast_i (mode_i[0]),
    .clear_i(load_i),
    .step_o (step)
  );

  assign yearend = (cur[F_MON] == 8'h12) &&
                   (cur[F_DAY] >= 8'h25) && (cur[F_DAY] <= 8'h27);

  always_comb begin
    hi[F_SEC]  = 8'h59;
    hi[F_MIN]  = 8'h59;
    hi[F_HOUR] = 8'h23;
    hi[F_DAY]  = month_len(cur[F_MON], cur[F_YEAR]);
    hi[F_MON]  = 8'h12;
    hi[F_YEAR] = 8'h99;
    hi[F_WDAY] = 8'h07;
    hi[F_WEEK] = 8'h52;
    for (int i = 0; i < NFIELD; i++) wrap[i] = FIELD_LO[i];
    wrap[F_WEEK] = yearend ? 8'h00 : 8'h01;
  end

  always_comb begin
    logic c_min, c_hour, c_day, c_mon, c_year, c_week;
    c_min  = step   && top[F_SEC];
    c_hour = c_min  && top[F_MIN];
    c_day  = c_hour && top[F_HOUR];
    c_mon  = c_day  && top[F_DAY];
    c_year = c_mon  && top[F_MON];
    c_week = c_day  && top[F_WDAY];
    if (mode_i[1]) begin
      inc = {NFIELD{step}};
    end else begin
      inc         = '0;
      inc[F_SEC]  = step;
      inc[F_MIN]  = c_min;
      inc[F_HOUR] = c_hour;
      inc[F_DAY]  = c_day;
      inc[F_WDAY] = c_day;
      inc[F_MON]  = c_mon;
      inc[F_YEAR] = c_year;
      inc[F_WEEK] = c_week;
    end
  end

  assign week_top_unused = top[F_WEEK];

  for (genvar g = 0; g < NFIELD; g++) begin : g_field
    cal_field #(
      .RST_VAL(FIELD_RST[g]),
      .LO_VAL (FIELD_LO[g])
    ) i_field (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .load_i    (load_i),
      .load_val_i(load_val_i[g*8 +: 8]),
      .inc_i     (inc[g]),
      .hi_i      (hi[g]),
      .wrap_val_i(wrap[g]),
      .val_o     (cur[g]),
      .at_top_o  (top[g])
    );
    assign time_o[g*8 +: 8] = cur[g];
  end
endmodule

// File: rtl/cal_checker.sv
module cal_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        tick_i,
  input logic [1:0]  mode_i,
  input logic        load_i,
  input logic [63:0] load_val_i,
  input logic [63:0] time_o
);
  p_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> time_o == $past(load_val_i));

  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !tick_i) |=> $stable(time_o));

  p_min_carry_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !mode_i[1] && time_o[7:0] != 8'h59) |=> $stable(time_o[15:8]));

  p_week_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !mode_i[1] && time_o[55:48] != 8'h07) |=> $stable(time_o[63:56]));

  p_parallel_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && tick_i && mode_i == 2'b11) |=>
      (time_o[7:0] != $past(time_o[7:0])) && (time_o[63:56] != $past(time_o[63:56])));
endmodule

bind bcd_calendar cal_checker i_cal_checker (.*);

// File: tb/test_bcd_calendar.sv
module test_bcd_calendar;
  typedef struct packed {
    logic [1:0]  mode;
    logic [63:0] start;
    logic [7:0]  nticks;
    logic [63:0] expect_v;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 28;
  // byte order in each value: week wday year mon day hour min sec
  localparam vec_t VECS [NV] = '{
    '{2'b01, 64'h10_03_23_05_14_10_20_58, 8'd1,  64'h10_03_23_05_14_10_20_59, 8'd4},  // R4
    '{2'b01, 64'h10_03_23_05_14_10_20_59, 8'd1,  64'h10_03_23_05_14_10_21_00, 8'd4},  // R4
    '{2'b01, 64'h10_03_23_05_14_10_59_59, 8'd1,  64'h10_03_23_05_14_11_00_00, 8'd4},  // R4
    '{2'b01, 64'h10_03_23_05_14_23_59_59, 8'd1,  64'h10_04_23_05_15_00_00_00, 8'd7},  // R7
    '{2'b01, 64'h08_03_24_02_28_23_59_59, 8'd1,  64'h08_04_24_02_29_00_00_00, 8'd5},  // R5
    '{2'b01, 64'h08_03_23_02_28_23_59_59, 8'd1,  64'h08_04_23_03_01_00_00_00, 8'd5},  // R5
    '{2'b01, 64'h08_03_24_02_29_23_59_59, 8'd1,  64'h08_04_24_03_01_00_00_00, 8'd5},  // R5
    '{2'b01, 64'h08_03_00_02_28_23_59_59, 8'd1,  64'h08_04_00_02_29_00_00_00, 8'd5},  // R5
    '{2'b01, 64'h16_03_23_04_30_23_59_59, 8'd1,  64'h16_04_23_05_01_00_00_00, 8'd5},  // R5
    '{2'b01, 64'h28_03_23_07_30_23_59_59, 8'd1,  64'h28_04_23_07_31_00_00_00, 8'd5},  // R5
    '{2'b01, 64'h52_03_99_12_31_23_59_59, 8'd1,  64'h52_04_00_01_01_00_00_00, 8'd6},  // R6
    '{2'b01, 64'h17_07_23_05_14_23_59_59, 8'd1,  64'h18_01_23_05_15_00_00_00, 8'd8},  // R8
    '{2'b01, 64'h52_07_20_12_26_23_59_59, 8'd1,  64'h00_01_20_12_27_00_00_00, 8'd8},  // R8
    '{2'b01, 64'h52_07_20_12_30_23_59_59, 8'd1,  64'h01_01_20_12_31_00_00_00, 8'd8},  // R8
    '{2'b01, 64'h52_07_20_12_24_23_59_59, 8'd1,  64'h01_01_20_12_25_00_00_00, 8'd8},  // R8
    '{2'b01, 64'h52_07_20_12_27_23_59_59, 8'd1,  64'h00_01_20_12_28_00_00_00, 8'd8},  // R8
    '{2'b01, 64'h20_06_23_05_14_23_59_59, 8'd1,  64'h20_07_23_05_15_00_00_00, 8'd8},  // R8
    '{2'b01, 64'h10_03_23_05_14_10_20_75, 8'd1,  64'h10_03_23_05_14_10_20_00, 8'd9},  // R9
    '{2'b01, 64'h10_03_23_05_14_25_59_59, 8'd1,  64'h10_03_23_05_14_00_00_00, 8'd9},  // R9
    '{2'b01, 64'h10_02_23_04_31_23_59_59, 8'd1,  64'h10_03_23_04_01_00_00_00, 8'd9},  // R9
    '{2'b01, 64'h10_09_23_05_14_23_59_59, 8'd1,  64'h10_01_23_05_15_00_00_00, 8'd9},  // R9
    '{2'b01, 64'h10_03_23_05_00_23_59_59, 8'd1,  64'h10_04_23_05_01_00_00_00, 8'd9},  // R9
    '{2'b11, 64'h10_03_23_05_14_10_20_58, 8'd1,  64'h11_04_24_06_15_11_21_59, 8'd10}, // R10
    '{2'b11, 64'h52_07_99_12_31_23_59_59, 8'd1,  64'h01_01_00_01_01_00_00_00, 8'd10}, // R10
    '{2'b10, 64'h10_03_23_05_14_10_20_58, 8'd32, 64'h11_04_24_06_15_11_21_59, 8'd10}, // R10
    '{2'b01, 64'h10_03_23_05_14_10_59_55, 8'd10, 64'h10_03_23_05_14_11_00_05, 8'd4},  // R4
    '{2'b00, 64'h10_03_23_05_14_10_20_10, 8'd64, 64'h10_03_23_05_14_10_20_12, 8'd3},  // R3
    '{2'b00, 64'h10_03_23_05_14_10_20_10, 8'd31, 64'h10_03_23_05_14_10_20_10, 8'd3}   // R3
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic [1:0]  mode_i = 2'b00;
  logic        load_i = 1'b0;
  logic [63:0] load_val_i = '0;
  logic [63:0] time_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  bcd_calendar i_bcd_calendar (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .mode_i    (mode_i),
    .load_i    (load_i),
    .load_val_i(load_val_i),
    .time_o    (time_o)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_load(input logic [1:0] m, input logic [63:0] v);
    @(negedge clk_i);
    mode_i = m; load_i = 1'b1; load_val_i = v;
    @(negedge clk_i);
    load_i = 1'b0;
  endtask

  task automatic do_ticks(input int n);
    if (n > 0) begin
      tick_i = 1'b1;
      repeat (n) @(negedge clk_i);
      tick_i = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [63:0] snap;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 reset value", time_o, 64'h01_01_00_01_01_00_00_00);

    for (int i = 0; i < NV; i++) begin
      do_load(VECS[i].mode, VECS[i].start);
      do_ticks(int'(VECS[i].nticks));
      check($sformatf("R%0d vector %0d", VECS[i].req, i), time_o, VECS[i].expect_v);
    end

    // R11: idle cycles leave the fields untouched
    snap = time_o;
    repeat (5) @(negedge clk_i);
    check("R11 hold without tick", time_o, snap);

    // R2: load wins over a tick in the same cycle
    @(negedge clk_i);
    mode_i = 2'b01; load_i = 1'b1; tick_i = 1'b1; load_val_i = 64'h33_05_45_09_17_08_30_40;
    @(negedge clk_i);
    load_i = 1'b0; tick_i = 1'b0;
    check("R2 load priority over tick", time_o, 64'h33_05_45_09_17_08_30_40);

    // R2: load restarts the prescaler
    do_load(2'b00, 64'h33_05_45_09_17_08_30_40);
    do_ticks(20);
    do_load(2'b00, 64'h33_05_45_09_17_08_30_40);
    do_ticks(31);
    check("R2 prescaler restart, 31 ticks", time_o, 64'h33_05_45_09_17_08_30_40);
    do_ticks(1);
    check("R2 prescaler restart, 32nd tick", time_o, 64'h33_05_45_09_17_08_30_41);

    // R3: fast mode steps on every tick
    do_load(2'b01, 64'h33_05_45_09_17_08_30_40);
    do_ticks(3);
    check("R3 fast mode three ticks", time_o, 64'h33_05_45_09_17_08_30_43);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule